// File: doc/BRIEF.md
# SD Data Phase Timeout Watchdog

This block guards the data phase of an SD card transfer. When the host starts a data phase it loads a 16-bit limit into a down counter. The counter then decrements once for every card clock tick. If the kilocycle mode is selected, it decrements once for every 1024 card clock ticks instead. The counter reloads whenever the data engine reports progress, such as a finished block. If the count runs out before progress is reported, the block sets a sticky timeout status bit and drives an interrupt line. It also requests an abort of the data transfer so that the host can issue a stop command.

A limit of zero turns off expiry in both modes. The limit and the mode are captured when the counter loads, so changes made during a phase only take effect at the next reload. Only one expiry can occur per loading. The status bit is cleared by writing a one to its position.

Top module: `sd_data_watchdog`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `sts_rd` is zero and `irq` and `abort_req` are low.
- R2: A data phase arms the counter at the first clock edge where `xfer_active` is high after being low. In cycle mode (`kilo_mode` = 0) with limit L > 0, the flag sets at the edge that carries the L-th `card_tick` after the arming edge. A tick on the arming edge itself does not count, and cycles without a tick do not count.
- R3: In kilocycle mode (`kilo_mode` = 1), each count takes 1024 card ticks, so expiry comes at the tick numbered L×1024 after arming.
- R4: A limit of 0 loaded in either mode never produces an expiry, however many ticks follow.
- R5: A `progress` pulse while `xfer_active` is high reloads the counter from `limit` and restarts the kilocycle prescaler. A `progress` pulse while `xfer_active` is low has no effect.
- R6: While `xfer_active` is low no counting or expiry happens. The next rise of `xfer_active` starts a full new count.
- R7: On expiry, bit 5 of `sts_rd` (the data timeout bit) becomes 1 from the next cycle. `irq` is high exactly while that bit is set. The bit stays set until it is cleared by a write.
- R8: A cycle with `sts_wr` high and bit 5 of `sts_wdata` set clears the timeout bit. A write with bit 5 clear leaves it unchanged. When an expiry and a clearing write occur in the same cycle, the bit ends up set.
- R9: `abort_req` rises on the cycle after an expiry and stays high until `xfer_active` is low at a clock edge.
- R10: After an expiry the counter stays idle until the next reload, so clearing the flag during the same phase never leads to a second expiry without a reload.
- R11: `limit` and `kilo_mode` are sampled only at a reload. Changing them mid-phase does not alter the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| card_tick | input | 1 | One-cycle enable for each card clock cycle |
| xfer_active | input | 1 | High for the duration of a data phase |
| progress | input | 1 | Reload strobe on data progress (for example, block done) |
| limit | input | 16 | Timeout value in counts; 0 disables expiry |
| kilo_mode | input | 1 | 0: one count per card tick; 1: one count per 1024 ticks |
| sts_wr | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | 16 | Status write data; bit 5 clears the timeout bit |
| sts_rd | output | 16 | Status word; bit 5 is the data timeout flag |
| irq | output | 1 | Interrupt request, high while the timeout flag is set |
| abort_req | output | 1 | Request to abort the data transfer after a timeout |

## Verification
If the remaining count or the prescaler phase is wrong, the timeout bit sets at the wrong edge. In cycle mode this shows within a few ticks of the expected expiry. In kilocycle mode it shows as an error that is a multiple of 1024 ticks. A missed reload on `progress` or a missed stop on an inactive phase appears as a spurious or absent flag rise in the following window. A broken write-one-to-clear or set-over-clear priority shows in `sts_rd` and `irq` on the cycle right after the write.

// File: rtl/sdwd_pkg.sv
// Shared parameters and types for the SD data phase timeout watchdog.
// Assumes: all users import this package before declaring ports.
package sdwd_pkg;
    localparam int unsigned LIMIT_W_DEF  = 16;
    localparam int unsigned PRE_W_DEF    = 10;
    localparam int unsigned STS_W_DEF    = 16;
    localparam int unsigned FLAG_BIT_DEF = 5;

    typedef enum logic {
        UNIT_CYCLE = 1'b0,
        UNIT_KILO  = 1'b1
    } unit_mode_e;
endpackage

// File: rtl/sdwd_prescaler.sv
// Turns gated card ticks into counting units.
// In cycle mode every tick is one unit. In kilocycle mode every 2**PRE_W ticks
// give one unit. Assumes: `tick` is already gated by the armed state, and
// `clear` restarts the phase.
module sdwd_prescaler
    import sdwd_pkg::*;
#(
    parameter int unsigned PRE_W = PRE_W_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       tick,
    input  unit_mode_e mode,
    output logic       unit
);
    generate
        if (PRE_W > 0) begin : g_div
            localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};
            logic [PRE_W-1:0] pre_q;

            // Advance the tick phase in kilocycle mode; restart on reload.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    pre_q <= '0;
                end else if (tick && mode == UNIT_KILO) begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            // A unit falls on every tick, or on the last tick of each kilocycle.
            always_comb begin
                unit = tick && (mode == UNIT_CYCLE || pre_q == PRE_LAST);
            end
        end else begin : g_nodiv
            // Without a prescaler every tick is a unit.
            always_comb begin
                unit = tick;
            end
        end
    endgenerate
endmodule

// File: rtl/sdwd_downcount.sv
// Holds the armed state and the remaining count for one data phase.
// It loads the limit and mode on a reload and decrements on each unit.
// It signals expiry on the unit that would take the count from 1 to 0 and
// then disarms. A loaded limit of 0 marks the phase unlimited.
// Assumes: `load` is only high while `active` is high.
module sdwd_downcount
    import sdwd_pkg::*;
#(
    parameter int unsigned LIMIT_W = LIMIT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               load,
    input  logic [LIMIT_W-1:0] limit,
    input  unit_mode_e         mode_in,
    input  logic               unit,
    output logic               armed,
    output unit_mode_e         mode_q,
    output logic               expire
);
    localparam logic [LIMIT_W-1:0] ONE = LIMIT_W'(1);

    logic [LIMIT_W-1:0] cnt_q;
    logic               unlim_q;

    // Expiry is the last unit of a limited, armed phase.
    always_comb begin
        expire = active && !load && armed && unit && !unlim_q && cnt_q == ONE;
    end

    // Arm and load on a reload, count units down, and disarm on expiry or end of phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            cnt_q   <= '0;
            unlim_q <= 1'b0;
            mode_q  <= UNIT_CYCLE;
        end else if (!active) begin
            armed <= 1'b0;
        end else if (load) begin
            armed   <= 1'b1;
            cnt_q   <= limit;
            unlim_q <= (limit == '0);
            mode_q  <= mode_in;
        end else if (armed && unit && !unlim_q) begin
            if (cnt_q == ONE) begin
                armed <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R2: a limited phase that is armed never holds a zero count.
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !unlim_q) |-> (cnt_q != '0));
endmodule

// File: rtl/sdwd_status.sv
// Sticky data timeout flag with write-one-to-clear, plus the abort request.
// A set from an expiry takes priority over a clear in the same cycle.
// The abort request holds from expiry until the data phase ends.
module sdwd_status
    import sdwd_pkg::*;
#(
    parameter int unsigned STS_W    = STS_W_DEF,
    parameter int unsigned FLAG_BIT = FLAG_BIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic             active,
    input  logic             sts_wr,
    input  logic [STS_W-1:0] sts_wdata,
    output logic [STS_W-1:0] sts_rd,
    output logic             flag,
    output logic             abort_req
);
    localparam logic [STS_W-1:0] FLAG_MASK = STS_W'(1) << FLAG_BIT;

    logic clr_hit;

    // A write clears the flag only when it has the flag's bit set.
    always_comb begin
        clr_hit = sts_wr && ((sts_wdata & FLAG_MASK) != '0);
        sts_rd  = flag ? FLAG_MASK : '0;
    end

    // Sticky flag: set on expiry, otherwise cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (clr_hit) begin
            flag <= 1'b0;
        end
    end

    // Abort request: raised on expiry, dropped once the phase is over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_req <= 1'b0;
        end else if (expire) begin
            abort_req <= 1'b1;
        end else if (!active) begin
            abort_req <= 1'b0;
        end
    end

    // R7: the flag stays set unless a clearing write arrives.
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_hit) |=> flag);

    // R8: a clearing write with no expiry drops the flag.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !expire) |=> !flag);
endmodule

// File: rtl/sd_data_watchdog.sv
// Top level of the SD data phase timeout watchdog.
// It detects the start of a data phase and progress reloads, gates card ticks
// into the prescaler, and connects the counter to the status flag.
// Assumes: card_tick is a one-cycle enable in the clk domain.
module sd_data_watchdog
    import sdwd_pkg::*;
#(
    parameter int unsigned LIMIT_W  = LIMIT_W_DEF,
    parameter int unsigned PRE_W    = PRE_W_DEF,
    parameter int unsigned STS_W    = STS_W_DEF,
    parameter int unsigned FLAG_BIT = FLAG_BIT_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               card_tick,
    input  logic               xfer_active,
    input  logic               progress,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               kilo_mode,
    input  logic               sts_wr,
    input  logic [STS_W-1:0]   sts_wdata,
    output logic [STS_W-1:0]   sts_rd,
    output logic               irq,
    output logic               abort_req
);
    logic       act_q;
    logic       load;
    logic       armed;
    logic       gtick;
    logic       unit;
    logic       expire;
    logic       flag;
    unit_mode_e mode_q;
    unit_mode_e mode_in;

    // Remember the previous phase state to find the start of a phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= xfer_active;
        end
    end

    // Reload on phase start or on progress; only ticks of an armed phase count.
    always_comb begin
        load    = xfer_active && (!act_q || progress);
        gtick   = card_tick && armed && xfer_active && !load;
        mode_in = kilo_mode ? UNIT_KILO : UNIT_CYCLE;
        irq     = flag;
    end

    sdwd_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .tick  (gtick),
        .mode  (mode_q),
        .unit  (unit)
    );

    sdwd_downcount #(.LIMIT_W(LIMIT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (xfer_active),
        .load    (load),
        .limit   (limit),
        .mode_in (mode_in),
        .unit    (unit),
        .armed   (armed),
        .mode_q  (mode_q),
        .expire  (expire)
    );

    sdwd_status #(.STS_W(STS_W), .FLAG_BIT(FLAG_BIT)) u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .active    (xfer_active),
        .sts_wr    (sts_wr),
        .sts_wdata (sts_wdata),
        .sts_rd    (sts_rd),
        .flag      (flag),
        .abort_req (abort_req)
    );

    // R6: an inactive phase cannot raise the flag at that edge.
    p_no_expire_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> !$rose(flag));

    // R9: the abort request holds while the phase is still active.
    p_abort_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && xfer_active) |=> abort_req);
endmodule

// File: tb/sim_sd_data_watchdog.sv
// Self-checking bench: a reference model written from the requirements,
// directed corner cases, and a seeded random phase.
module sim_sd_data_watchdog;
    localparam int KILO = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_tick = 1'b0;
    logic        xfer_active = 1'b0;
    logic        progress = 1'b0;
    logic [15:0] limit = 16'd0;
    logic        kilo_mode = 1'b0;
    logic        sts_wr = 1'b0;
    logic [15:0] sts_wdata = 16'd0;
    logic [15:0] sts_rd;
    logic        irq;
    logic        abort_req;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    sd_data_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .card_tick(card_tick), .xfer_active(xfer_active),
        .progress(progress), .limit(limit), .kilo_mode(kilo_mode), .sts_wr(sts_wr),
        .sts_wdata(sts_wdata), .sts_rd(sts_rd), .irq(irq), .abort_req(abort_req)
    );

    // Reference model state
    logic        m_act, m_armed, m_unl, m_kilo, m_flag, m_abort;
    logic [15:0] m_cnt;
    int          m_pre;

    // Expected status word from the model flag (bit 5 per R7).
    function automatic logic [15:0] exp_sts(input logic f);
        return f ? 16'h0020 : 16'h0000;
    endfunction

    // Reference model built from R2..R11.
    always @(posedge clk) begin : mdl
        logic ld, un, ex;
        if (!rst_n) begin
            m_act = 0; m_armed = 0; m_unl = 0; m_kilo = 0; m_flag = 0; m_abort = 0;
            m_cnt = 0; m_pre = 0;
        end else begin
            ld = xfer_active && (!m_act || progress);
            ex = 0;
            if (!xfer_active) begin
                m_armed = 0;
            end else if (ld) begin
                m_armed = 1; m_cnt = limit; m_unl = (limit == 0); m_kilo = kilo_mode; m_pre = 0;
            end else if (m_armed && card_tick) begin
                un = !m_kilo || (m_pre == KILO - 1);
                m_pre = (m_pre + 1) % KILO;
                if (un && !m_unl) begin
                    if (m_cnt == 1) begin ex = 1; m_armed = 0; end
                    else m_cnt = m_cnt - 1;
                end
            end
            if (ex) m_flag = 1;
            else if (sts_wr && sts_wdata[5]) m_flag = 0;
            if (ex) m_abort = 1;
            else if (!xfer_active) m_abort = 0;
            m_act = xfer_active;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: wait for the edge, then compare against the model at the negedge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) begin
            chk({cur_req, " sts"}, sts_rd, exp_sts(m_flag));
            chk({cur_req, " irq"}, {15'd0, irq}, {15'd0, m_flag});
            chk({cur_req, " abort"}, {15'd0, abort_req}, {15'd0, m_abort});
        end
    endtask

    task automatic idle_all();
        card_tick = 0; progress = 0; sts_wr = 0; sts_wdata = 0;
    endtask

    task automatic end_phase();
        idle_all(); xfer_active = 0; cyc(); cyc();
    endtask

    task automatic clear_flag();
        sts_wr = 1; sts_wdata = 16'h0020; cyc(); sts_wr = 0; sts_wdata = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        // R1: state after reset
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 sts", sts_rd, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 abort", {15'd0, abort_req}, 16'd0);

        // R2: cycle mode, limit 5, tick every cycle -> flag after 5 edges past arming
        cur_req = "R2";
        limit = 5; kilo_mode = 0; xfer_active = 1; card_tick = 1;
        for (int i = 1; i <= 5; i++) begin
            cyc();
            chk("R2 before expiry", sts_rd, 16'h0000);
        end
        cyc();
        chk("R2 expiry bit5", sts_rd, 16'h0020);
        chk("R9 abort after expiry", {15'd0, abort_req}, 16'd1);
        // R10: clear in-phase, keep ticking; no second expiry
        cur_req = "R10";
        clear_flag();
        card_tick = 1;
        repeat (20) cyc();
        chk("R10 no re-expiry", sts_rd, 16'h0000);
        chk("R9 abort held", {15'd0, abort_req}, 16'd1);
        cur_req = "R9";
        end_phase();
        chk("R9 abort dropped", {15'd0, abort_req}, 16'd0);

        // R2: sparse ticks, every third cycle
        cur_req = "R2";
        limit = 4; xfer_active = 1;
        for (int i = 0; i < 20; i++) begin card_tick = (i % 3 == 2); cyc(); end
        chk("R2 sparse ticks", sts_rd, 16'h0020);
        end_phase(); clear_flag();

        // R3: kilocycle mode, limit 2 -> 2048 ticks
        cur_req = "R3";
        limit = 2; kilo_mode = 1; xfer_active = 1; card_tick = 1;
        cyc();
        for (int i = 1; i < 2 * KILO; i++) cyc();
        chk("R3 not yet at 2047", sts_rd, 16'h0000);
        cyc();
        chk("R3 expiry at 2048", sts_rd, 16'h0020);
        end_phase(); clear_flag();

        // R4: zero limit in both modes
        cur_req = "R4";
        for (int m = 0; m < 2; m++) begin
            limit = 0; kilo_mode = m[0]; xfer_active = 1; card_tick = 1;
            repeat (2100) cyc();
            chk("R4 zero limit unlimited", sts_rd, 16'h0000);
            end_phase();
        end

        // R5: progress keeps reloading; inactive progress ignored
        cur_req = "R5";
        limit = 6; kilo_mode = 0; xfer_active = 1; card_tick = 1;
        for (int i = 0; i < 30; i++) begin progress = (i % 5 == 4); cyc(); end
        chk("R5 reloads prevent expiry", sts_rd, 16'h0000);
        end_phase();
        progress = 1; cyc(); progress = 0; cyc();
        chk("R5 inactive progress ignored", sts_rd, 16'h0000);

        // R6: dropping the phase stops counting; re-raise restarts from full
        cur_req = "R6";
        limit = 6; xfer_active = 1; card_tick = 1;
        repeat (4) cyc();
        xfer_active = 0; repeat (10) cyc();
        chk("R6 idle no expiry", sts_rd, 16'h0000);
        xfer_active = 1; repeat (6) cyc();
        chk("R6 fresh count, not yet", sts_rd, 16'h0000);
        cyc();
        chk("R6 fresh count expiry", sts_rd, 16'h0020);
        end_phase();

        // R8: write with bit 5 clear ignored, set beats clear
        cur_req = "R8";
        sts_wr = 1; sts_wdata = 16'hFFDF; cyc(); sts_wr = 0;
        chk("R8 other bits no clear", sts_rd, 16'h0020);
        clear_flag();
        chk("R8 w1c clears", sts_rd, 16'h0000);
        limit = 2; xfer_active = 1; card_tick = 1;
        cyc(); cyc();
        sts_wr = 1; sts_wdata = 16'h0020; cyc(); sts_wr = 0;
        chk("R8 set wins over clear", sts_rd, 16'h0020);
        end_phase(); clear_flag();

        // R11: mid-phase changes of limit and mode ignored
        cur_req = "R11";
        limit = 3; kilo_mode = 0; xfer_active = 1; card_tick = 1;
        cyc(); limit = 40; kilo_mode = 1;
        cyc(); cyc(); cyc();
        chk("R11 captured limit used", sts_rd, 16'h0020);
        end_phase(); clear_flag();

        // Random phase, all requirements against the model
        cur_req = "R2/R5/R6/R8 random";
        void'($urandom(32'd12345));
        for (int i = 0; i < 30000; i++) begin
            card_tick = ($urandom % 10) < 7;
            progress  = ($urandom % 40) == 0;
            if (($urandom % 60) == 0) xfer_active = ~xfer_active;
            sts_wr    = ($urandom % 25) == 0;
            sts_wdata = 16'($urandom);
            if (($urandom % 30) == 0) limit = 16'($urandom % 16);
            if (($urandom % 200) == 0) kilo_mode = ~kilo_mode;
            cyc();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule